// File: doc/BRIEF.md
# x86 Instruction Prefix Scanner

This block examines the leading bytes of a single x86 instruction and works out how its prefix area is built before the opcode is decoded. A start pulse captures a window of instruction bytes, a count of how many of those bytes are valid, and a mode bit that selects 32-bit or 64-bit decoding. The scanner reads one byte per clock. It first consumes the legacy prefixes, then an optional REX byte, then an optional two-, three- or four-byte vector prefix (VEX2, VEX3 or EVEX). A done pulse marks the point at which the results are ready.

The results are: the recorded legacy prefix slots, the number of legacy prefix bytes consumed, the REX byte with a valid flag, the vector prefix payload bytes with their count, the effective operand and address sizes in bytes, and the offset of the first opcode byte. An error flag reports that the scan needed a byte that lies beyond the valid count. While the error flag is high, the other outputs carry no meaning. A downstream opcode decoder reads these values as its starting context.

Top module: `x86_prefix_scanner`

## Requirements
- R1: After reset, `done_o` and `err_o` are low. An instruction that has no prefixes gives an operand size of 4 and an address size of 8 in 64-bit mode or 4 in 32-bit mode. Sizes are reported as byte counts (2, 4 or 8).
- R2: A valid count above 15 is treated as 15, so byte index 15 of the window is never examined.
- R3: Legacy prefixes are 26h, 2Eh, 36h, 3Eh, 64h, 65h, 66h, 67h, F0h, F2h and F3h. A repeat of a prefix that is already recorded is consumed and counted in `pfx_cnt_o` but is not stored again. Slots are filled from slot 0 upward, and unused slots read 00h.
- R4: At most four distinct prefixes are stored. A fifth distinct prefix ends the legacy scan, and that byte's offset becomes the opcode offset.
- R5: Each newly stored 66h flips the operand size between 4 and 2. Each newly stored 67h flips the address size between 8 and 4 in 64-bit mode, or between 4 and 2 in 32-bit mode.
- R6: After the legacy scan, slot 3 (bits 31:24 of `slots_o`) holds the last prefix consumed. If slot 3 held a different non-zero byte, every slot that held the last prefix takes the old slot-3 byte.
- R7: In 64-bit mode only, a byte 40h–4Fh right after the legacy prefixes is taken as REX. If its bit 3 is set, the operand size is 8. In 32-bit mode such a byte is left as the opcode.
- R8: C5h, C4h and 62h open a VEX2, VEX3 or EVEX prefix respectively. In 32-bit mode they do so only when bits 7:6 of the following byte are both 1. Otherwise no vector prefix is recorded, and the opcode starts at that byte.
- R9: EVEX consumes 4 bytes and VEX3 consumes 3 bytes. Their bytes appear in order in `vex_o`, with byte 0 in bits 7:0. In 64-bit mode, bit 7 of the last payload byte set forces the operand size to 8.
- R10: VEX2 consumes 2 bytes and reports a length of 2. Payload byte 2 is a copy of payload byte 1 with bit 7 cleared.
- R11: If the scan needs a byte at or beyond the clamped valid count, `err_o` is raised with the done pulse.
- R12: `done_o` is high for exactly one cycle. Counted in clock edges after the start edge, it rises at edge P+5 with no prefix or with VEX2, at P+6 with VEX3 and at P+7 with EVEX, where P is `pfx_cnt_o`. A failure in the legacy stage gives P+2, at the REX check P+4, and otherwise the edge of the stage that failed. The opcode offset equals the legacy count plus the REX byte plus the vector length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a scan; accepted only while idle |
| mode64_i | input | 1 | 1 selects 64-bit decoding, 0 selects 32-bit |
| win_i | input | WIN_BYTES*8 | Instruction bytes, byte i at bits 8i+7:8i |
| avail_i | input | CNT_W | Number of valid bytes in the window |
| done_o | output | 1 | One-cycle pulse when the results are ready |
| err_o | output | 1 | The scan ran past the valid bytes |
| slots_o | output | NSLOT*8 | Recorded legacy prefixes, slot i at bits 8i+7:8i |
| pfx_cnt_o | output | CNT_W | Legacy prefix bytes consumed, repeats included |
| rex_vld_o | output | 1 | A REX byte was taken |
| rex_o | output | 8 | The REX byte |
| vex_o | output | 32 | Vector prefix payload bytes |
| vex_len_o | output | 3 | Vector prefix length: 0, 2, 3 or 4 |
| opnd_sz_o | output | 4 | Effective operand size in bytes |
| addr_sz_o | output | 4 | Effective address size in bytes |
| opc_off_o | output | CNT_W | Offset of the first opcode byte |

## Verification
The hardest case to reach is the slot-3 swap. It needs four distinct prefixes so that slot 3 is occupied, followed by a repeat of an earlier prefix so that the last byte consumed differs from slot 3. The bench builds that sequence directly. It also builds the five-distinct stop and the length-clamped run of fifteen prefixes. A seeded generator then produces windows drawn from a small alphabet that is rich in prefixes, vector prefix bytes and mode-bit patterns, in both modes and with short valid counts. This drives the repeat, swap and truncation paths in many combinations against a behavioural model that predicts the done cycle for every run.

// File: rtl/pfxscan_pkg.sv
`timescale 1ns/1ps
package pfxscan_pkg;

  typedef enum logic [2:0] {
    BK_OTHER, BK_LEG, BK_OPSZ, BK_ADSZ, BK_REX, BK_VEX2, BK_VEX3, BK_EVEX
  } byte_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEG, ST_FIX, ST_REX, ST_VEX, ST_VP2, ST_VP3, ST_FIN
  } scan_st_e;

  function automatic byte_kind_e kind_of(input logic [7:0] b);
    byte_kind_e k;
    case (b)
      8'h66: k = BK_OPSZ;
      8'h67: k = BK_ADSZ;
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'hF0, 8'hF2, 8'hF3: k = BK_LEG;
      8'hC5: k = BK_VEX2;
      8'hC4: k = BK_VEX3;
      8'h62: k = BK_EVEX;
      default: k = (b[7:4] == 4'h4) ? BK_REX : BK_OTHER;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pfx_byte_class.sv
`timescale 1ns/1ps
module pfx_byte_class
  import pfxscan_pkg::*;
(
  input  logic [7:0] byte_i,
  output byte_kind_e kind_o,
  output logic       legacy_o
);
  assign kind_o   = kind_of(byte_i);
  assign legacy_o = (kind_o == BK_LEG) || (kind_o == BK_OPSZ) || (kind_o == BK_ADSZ);
endmodule

// File: rtl/pfx_slot_file.sv
`timescale 1ns/1ps
module pfx_slot_file #(
  parameter int NSLOT = 4,
  localparam int FW = $clog2(NSLOT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               store_i,
  input  logic               fix_i,
  input  logic [7:0]         byte_i,
  input  logic [7:0]         last_i,
  output logic               hit_o,
  output logic               full_o,
  output logic [NSLOT*8-1:0] slots_o
);
  logic [FW-1:0]    fill_q;
  logic [NSLOT-1:0] match;
  logic [7:0]       top_b;
  logic             do_fix;

  assign top_b  = slots_o[(NSLOT-1)*8 +: 8];
  assign do_fix = fix_i && (last_i != 8'h00) && (last_i != top_b);
  assign hit_o  = |match;
  assign full_o = (fill_q == FW'(NSLOT));

  generate
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
      logic [7:0] q;
      assign slots_o[gi*8 +: 8] = q;
      assign match[gi] = (FW'(gi) < fill_q) && (q == byte_i);
      always_ff @(posedge clk) begin
        if (rst || clr_i) begin
          q <= 8'h00;
        end else if (store_i && (fill_q == FW'(gi))) begin
          q <= byte_i;
        end else if (do_fix) begin
          if (gi == NSLOT - 1) begin
            q <= last_i;
          end else if ((FW'(gi) < fill_q) && (q == last_i) && (top_b != 8'h00)) begin
            q <= top_b;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      fill_q <= '0;
    end else if (store_i) begin
      fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfx_size_track.sv
`timescale 1ns/1ps
module pfx_size_track #(
  parameter int SZW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_i,
  input  logic           mode64_i,
  input  logic           tog_op_i,
  input  logic           tog_ad_i,
  input  logic           force8_i,
  output logic [SZW-1:0] opnd_o,
  output logic [SZW-1:0] addr_o
);
  localparam logic [SZW-1:0] SZ2     = SZW'(2);
  localparam logic [SZW-1:0] SZ4     = SZW'(4);
  localparam logic [SZW-1:0] SZ8     = SZW'(8);
  localparam logic [SZW-1:0] FLIP_24 = SZ2 ^ SZ4;
  localparam logic [SZW-1:0] FLIP_48 = SZ4 ^ SZ8;

  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_o <= SZ4;
      addr_o <= SZ4;
      mode_q <= 1'b0;
    end else if (init_i) begin
      opnd_o <= SZ4;
      addr_o <= mode64_i ? SZ8 : SZ4;
      mode_q <= mode64_i;
    end else begin
      if (force8_i)      opnd_o <= SZ8;
      else if (tog_op_i) opnd_o <= opnd_o ^ FLIP_24;
      if (tog_ad_i)      addr_o <= addr_o ^ (mode_q ? FLIP_48 : FLIP_24);
    end
  end
endmodule

// File: rtl/x86_prefix_scanner.sv
`timescale 1ns/1ps
module x86_prefix_scanner
  import pfxscan_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_LEN   = 15,
  parameter int NSLOT     = 4,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   mode64_i,
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [CNT_W-1:0]       avail_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [NSLOT*8-1:0]     slots_o,
  output logic [CNT_W-1:0]       pfx_cnt_o,
  output logic                   rex_vld_o,
  output logic [7:0]             rex_o,
  output logic [31:0]            vex_o,
  output logic [2:0]             vex_len_o,
  output logic [3:0]             opnd_sz_o,
  output logic [3:0]             addr_sz_o,
  output logic [CNT_W-1:0]       opc_off_o
);
  localparam logic [CNT_W-1:0] LEN_CAP  = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_BYTES - 1);

  scan_st_e               st_q;
  logic [WIN_BYTES*8-1:0] win_q;
  logic [CNT_W-1:0]       lim_q, ptr_q, ptr1, lim_in;
  logic                   mode_q;
  logic [7:0]             last_q;
  logic [3:0][7:0]        vex_q;
  byte_kind_e             vkind_q;
  logic [7:0]             cur_b, nxt_b;
  byte_kind_e             kind;
  logic                   is_leg, hit, full;
  logic                   end_cur, end_nxt;
  logic                   sl_store, sl_fix, tog_op, tog_ad, force8, init;

  assign lim_in  = (avail_i > LEN_CAP) ? LEN_CAP : avail_i;
  assign ptr1    = ptr_q + 1'b1;
  assign end_cur = (ptr_q >= lim_q);
  assign end_nxt = (ptr1 >= lim_q);
  assign init    = (st_q == ST_IDLE) && start_i;
  assign vex_o   = vex_q;

  always_comb begin
    cur_b = 8'h00;
    nxt_b = 8'h00;
    if (ptr_q <= LAST_IDX) cur_b = win_q[{ptr_q, 3'b000} +: 8];
    if (ptr1 <= LAST_IDX)  nxt_b = win_q[{ptr1, 3'b000} +: 8];
  end

  pfx_byte_class u_class (
    .byte_i   (cur_b),
    .kind_o   (kind),
    .legacy_o (is_leg)
  );

  always_comb begin
    sl_store = 1'b0;
    sl_fix   = (st_q == ST_FIX);
    tog_op   = 1'b0;
    tog_ad   = 1'b0;
    force8   = 1'b0;
    if ((st_q == ST_LEG) && !end_cur && is_leg && !hit && !full) begin
      sl_store = 1'b1;
      tog_op   = (kind == BK_OPSZ);
      tog_ad   = (kind == BK_ADSZ);
    end
    if ((st_q == ST_REX) && mode_q && !end_cur && (kind == BK_REX) && cur_b[3])
      force8 = 1'b1;
    if ((st_q == ST_VP2) && !end_cur && (vkind_q == BK_VEX3) && mode_q && cur_b[7])
      force8 = 1'b1;
    if ((st_q == ST_VP3) && !end_cur && mode_q && cur_b[7])
      force8 = 1'b1;
  end

  pfx_slot_file #(.NSLOT(NSLOT)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (init),
    .store_i (sl_store),
    .fix_i   (sl_fix),
    .byte_i  (cur_b),
    .last_i  (last_q),
    .hit_o   (hit),
    .full_o  (full),
    .slots_o (slots_o)
  );

  pfx_size_track #(.SZW(4)) u_size (
    .clk      (clk),
    .rst      (rst),
    .init_i   (init),
    .mode64_i (mode64_i),
    .tog_op_i (tog_op),
    .tog_ad_i (tog_ad),
    .force8_i (force8),
    .opnd_o   (opnd_sz_o),
    .addr_o   (addr_sz_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      win_q     <= '0;
      lim_q     <= '0;
      mode_q    <= 1'b0;
      ptr_q     <= '0;
      pfx_cnt_o <= '0;
      last_q    <= 8'h00;
      rex_o     <= 8'h00;
      rex_vld_o <= 1'b0;
      vex_q     <= '0;
      vex_len_o <= 3'd0;
      vkind_q   <= BK_OTHER;
      err_o     <= 1'b0;
      done_o    <= 1'b0;
      opc_off_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            win_q     <= win_i;
            lim_q     <= lim_in;
            mode_q    <= mode64_i;
            ptr_q     <= '0;
            pfx_cnt_o <= '0;
            last_q    <= 8'h00;
            rex_o     <= 8'h00;
            rex_vld_o <= 1'b0;
            vex_q     <= '0;
            vex_len_o <= 3'd0;
            vkind_q   <= BK_OTHER;
            err_o     <= 1'b0;
            st_q      <= ST_LEG;
          end
        end
        ST_LEG: begin
          if (end_cur) begin
            err_o <= 1'b1;
            st_q  <= ST_FIN;
          end else if (is_leg && (hit || !full)) begin
            pfx_cnt_o <= pfx_cnt_o + 1'b1;
            ptr_q     <= ptr1;
            last_q    <= cur_b;
          end else begin
            st_q <= ST_FIX;
          end
        end
        ST_FIX: st_q <= ST_REX;
        ST_REX: begin
          st_q <= ST_VEX;
          if (mode_q) begin
            if (end_cur) begin
              err_o <= 1'b1;
              st_q  <= ST_FIN;
            end else if (kind == BK_REX) begin
              rex_o     <= cur_b;
              rex_vld_o <= 1'b1;
              ptr_q     <= ptr1;
            end
          end
        end
        ST_VEX: begin
          st_q <= ST_FIN;
          if (end_cur) begin
            err_o <= 1'b1;
          end else if ((kind == BK_VEX2) || (kind == BK_VEX3) || (kind == BK_EVEX)) begin
            if (end_nxt) begin
              err_o <= 1'b1;
            end else if (mode_q || (nxt_b[7:6] == 2'b11)) begin
              vex_q[0] <= cur_b;
              vex_q[1] <= nxt_b;
              vkind_q  <= kind;
              ptr_q    <= ptr_q + CNT_W'(2);
              if (kind == BK_VEX2) begin
                vex_q[2]  <= nxt_b & 8'h7F;
                vex_len_o <= 3'd2;
              end else begin
                st_q <= ST_VP2;
              end
            end
          end
        end
        ST_VP2: begin
          st_q <= ST_FIN;
          if (end_cur) begin
            err_o <= 1'b1;
          end else begin
            vex_q[2] <= cur_b;
            ptr_q    <= ptr1;
            if (vkind_q == BK_VEX3) vex_len_o <= 3'd3;
            else                    st_q      <= ST_VP3;
          end
        end
        ST_VP3: begin
          st_q <= ST_FIN;
          if (end_cur) begin
            err_o <= 1'b1;
          end else begin
            vex_q[3]  <= cur_b;
            ptr_q     <= ptr1;
            vex_len_o <= 3'd4;
          end
        end
        ST_FIN: begin
          done_o    <= 1'b1;
          opc_off_o <= ptr_q;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfx_scan_chk.sv
`timescale 1ns/1ps
module pfx_scan_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             err,
  input logic             mode64,
  input logic             rexv,
  input logic [CNT_W-1:0] pcnt,
  input logic [CNT_W-1:0] off,
  input logic [2:0]       vlen,
  input logic [7:0]       slot_top,
  input logic [3:0]       opnd,
  input logic [3:0]       addr
);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_offset_sum_R12: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((CNT_W+1)'(off) ==
      (CNT_W+1)'(pcnt) + (CNT_W+1)'(rexv) + (CNT_W+1)'(vlen)));

  assert_rex_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !err && rexv) |-> mode64);

  assert_last_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !err && (pcnt != '0)) |-> (slot_top != 8'h00));

  assert_opnd_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (opnd == 4'd2) || (opnd == 4'd4) || (opnd == 4'd8));

  assert_addr_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (mode64 ? ((addr == 4'd8) || (addr == 4'd4))
                               : ((addr == 4'd4) || (addr == 4'd2))));

  assert_vex_len_R9: assert property (@(posedge clk) disable iff (rst)
    (vlen == 3'd0) || (vlen == 3'd2) || (vlen == 3'd3) || (vlen == 3'd4));

  assert_no_w_in_32_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !err && !mode64) |-> (opnd != 4'd8));
endmodule

bind x86_prefix_scanner pfx_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done_o),
  .err      (err_o),
  .mode64   (mode_q),
  .rexv     (rex_vld_o),
  .pcnt     (pfx_cnt_o),
  .off      (opc_off_o),
  .vlen     (vex_len_o),
  .slot_top (slots_o[NSLOT*8-1 -: 8]),
  .opnd     (opnd_sz_o),
  .addr     (addr_sz_o)
);

// File: tb/x86_prefix_scanner_tb.sv
`timescale 1ns/1ps
module x86_prefix_scanner_tb;
  localparam int WB = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, start, mode64;
  logic [WB*8-1:0] win;
  logic [CW-1:0] avail;
  logic          done, err, rexv;
  logic [31:0]   slots, vex;
  logic [CW-1:0] pcnt, off;
  logic [7:0]    rex;
  logic [2:0]    vlen;
  logic [3:0]    opnd, addr;

  x86_prefix_scanner u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mode64_i(mode64), .win_i(win),
    .avail_i(avail), .done_o(done), .err_o(err), .slots_o(slots),
    .pfx_cnt_o(pcnt), .rex_vld_o(rexv), .rex_o(rex), .vex_o(vex),
    .vex_len_o(vlen), .opnd_sz_o(opnd), .addr_sz_o(addr), .opc_off_o(off)
  );

  int nchk = 0;
  int nerr = 0;
  logic [7:0] w [WB];

  int e_err, e_lat, e_cnt, e_rexv, e_rex, e_vlen, e_op, e_ad, e_off;
  int e_slots [4];
  int e_vex [4];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_leg(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) || (b == 8'h3E) ||
           (b == 8'h64) || (b == 8'h65) || (b == 8'h66) || (b == 8'h67) ||
           (b == 8'hF0) || (b == 8'hF2) || (b == 8'hF3);
  endfunction

  task automatic model(input bit m64, input int cnt);
    int lim, ptr, nb, p;
    bit found;
    logic [7:0] b, b2, lb;
    lim = (cnt > 15) ? 15 : cnt;
    e_err = 0; e_cnt = 0; e_rexv = 0; e_rex = 0; e_vlen = 0; e_off = 0;
    for (int i = 0; i < 4; i++) begin e_slots[i] = 0; e_vex[i] = 0; end
    e_op = 4; e_ad = m64 ? 8 : 4;
    ptr = 0; nb = 0; p = 0; lb = 8'h00;
    forever begin
      if (ptr >= lim) begin e_err = 1; e_lat = p + 2; return; end
      b = w[ptr];
      if (!is_leg(b)) break;
      found = 0;
      for (int i = 0; i < nb; i++) if (e_slots[i] == int'(b)) found = 1;
      if (!found) begin
        if (nb == 4) break;
        e_slots[nb] = int'(b);
        nb++;
        if (b == 8'h66) e_op = e_op ^ 6;
        if (b == 8'h67) e_ad = e_ad ^ (m64 ? 12 : 6);
      end
      p++; ptr++; lb = b;
    end
    if (lb != 8'h00 && int'(lb) != e_slots[3]) begin
      if (e_slots[3] != 0)
        for (int i = 0; i < nb; i++) if (e_slots[i] == int'(lb)) e_slots[i] = e_slots[3];
      e_slots[3] = int'(lb);
    end
    e_cnt = p;
    if (m64) begin
      if (ptr >= lim) begin e_err = 1; e_lat = p + 4; return; end
      b = w[ptr];
      if (b[7:4] == 4'h4) begin
        e_rexv = 1; e_rex = int'(b); ptr++;
        if (b[3]) e_op = 8;
      end
    end
    if (ptr >= lim) begin e_err = 1; e_lat = p + 5; return; end
    b = w[ptr];
    if (b == 8'hC4 || b == 8'hC5 || b == 8'h62) begin
      if (ptr + 1 >= lim) begin e_err = 1; e_lat = p + 5; return; end
      b2 = w[ptr+1];
      if (!m64 && b2[7:6] != 2'b11) begin e_off = ptr; e_lat = p + 5; return; end
      e_vex[0] = int'(b); e_vex[1] = int'(b2);
      if (b == 8'hC5) begin
        e_vex[2] = int'(b2 & 8'h7F); e_vlen = 2; e_off = ptr + 2; e_lat = p + 5; return;
      end
      if (ptr + 2 >= lim) begin e_err = 1; e_lat = p + 6; return; end
      e_vex[2] = int'(w[ptr+2]);
      if (b == 8'hC4) begin
        e_vlen = 3; if (m64 && w[ptr+2][7]) e_op = 8;
        e_off = ptr + 3; e_lat = p + 6; return;
      end
      if (ptr + 3 >= lim) begin e_err = 1; e_lat = p + 7; return; end
      e_vex[3] = int'(w[ptr+3]); e_vlen = 4;
      if (m64 && w[ptr+3][7]) e_op = 8;
      e_off = ptr + 4; e_lat = p + 7; return;
    end
    e_off = ptr; e_lat = p + 5;
  endtask

  task automatic setw(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    for (int i = 0; i < WB; i++) w[i] = 8'h90;
    w[0] = b0; w[1] = b1; w[2] = b2; w[3] = b3;
    w[4] = b4; w[5] = b5; w[6] = b6; w[7] = b7;
  endtask

  task automatic run(input bit m64, input int cnt);
    model(m64, cnt);
    @(negedge clk);
    for (int i = 0; i < WB; i++) win[i*8 +: 8] = w[i];
    avail = CW'(cnt); mode64 = m64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= e_lat; k++) begin
      @(negedge clk);
      if (k < e_lat) chk("R12", "done before expected edge", int'(done), 0);
      else           chk("R12", "done at expected edge", int'(done), 1);
    end
    chk("R11", "error flag", int'(err), e_err);
    if (e_err == 0) begin
      for (int i = 0; i < 3; i++) chk("R3", "slot", int'(slots[i*8 +: 8]), e_slots[i]);
      chk("R6", "slot 3", int'(slots[31:24]), e_slots[3]);
      chk("R3", "prefix count", int'(pcnt), e_cnt);
      chk("R7", "rex valid", int'(rexv), e_rexv);
      chk("R7", "rex byte", int'(rex), e_rex);
      for (int i = 0; i < 4; i++) chk("R9", "vector byte", int'(vex[i*8 +: 8]), e_vex[i]);
      chk("R9", "vector length", int'(vlen), e_vlen);
      chk("R5", "operand size", int'(opnd), e_op);
      chk("R5", "address size", int'(addr), e_ad);
      chk("R12", "opcode offset", int'(off), e_off);
    end
    @(negedge clk);
    chk("R12", "done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [7:0] alpha [16];
    rst = 1'b1; start = 1'b0; mode64 = 1'b0; win = '0; avail = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "error after reset", int'(err), 0);

    setw(8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 4);
    chk("R1", "64-bit default operand", int'(opnd), 4);
    chk("R1", "64-bit default address", int'(addr), 8);
    run(1'b0, 4);
    chk("R1", "32-bit default address", int'(addr), 4);

    setw(8'h66, 8'h66, 8'hF3, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R3", "repeat not stored", int'(slots[15:8]), 8'hF3);
    chk("R5", "one toggle for repeated 66", int'(opnd), 2);

    setw(8'h66, 8'h67, 8'hF0, 8'hF2, 8'h2E, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R4", "fifth distinct stops scan", int'(off), 4);

    setw(8'hF2, 8'h66, 8'h67, 8'h2E, 8'hF2, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R6", "slot 0 takes old slot 3", int'(slots[7:0]), 8'h2E);
    chk("R6", "slot 3 takes last", int'(slots[31:24]), 8'hF2);

    setw(8'h67, 8'h67, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b0, 8);
    chk("R5", "32-bit address flip", int'(addr), 2);
    run(1'b1, 8);
    chk("R5", "64-bit address flip", int'(addr), 4);

    setw(8'h66, 8'h48, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R7", "REX.W forces 8", int'(opnd), 8);
    run(1'b0, 8);
    chk("R7", "no REX in 32-bit", int'(rexv), 0);

    setw(8'hC4, 8'h00, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b0, 8);
    chk("R8", "mode bits not 11 gives no prefix", int'(vlen), 0);
    setw(8'hC4, 8'hE1, 8'hFD, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b0, 8);
    chk("R8", "accepted in 32-bit", int'(vlen), 3);
    run(1'b1, 8);
    chk("R9", "VEX3 W in 64-bit", int'(opnd), 8);
    setw(8'h62, 8'hF1, 8'h7D, 8'hC8, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R9", "EVEX length", int'(vlen), 4);
    setw(8'hC5, 8'hF8, 8'h77, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 8);
    chk("R10", "synthetic byte", int'(vex[23:16]), 8'h78);

    setw(8'h66, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 1);
    chk("R11", "ran out after prefix", int'(err), 1);
    run(1'b0, 0);
    setw(8'h62, 8'hF1, 8'h7D, 8'hC8, 8'h90, 8'h90, 8'h90, 8'h90);
    run(1'b1, 3);
    chk("R11", "truncated EVEX", int'(err), 1);

    for (int i = 0; i < WB; i++) w[i] = 8'h26;
    w[15] = 8'h90;
    run(1'b1, 16);
    chk("R2", "count clamped to 15", int'(err), 1);

    alpha = '{8'h26, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h48,
              8'h40, 8'hC4, 8'hC5, 8'h62, 8'hE1, 8'h7D, 8'hFD, 8'h90};
    lfsr = 32'h1D5E_A7C3;
    for (int t = 0; t < 120; t++) begin
      for (int i = 0; i < WB; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        w[i] = alpha[lfsr[3:0]];
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run(lfsr[7], int'(lfsr[4:0] % 17));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule